// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block collects the data bytes of a serial memory write command into a one-page staging latch. When the command ends, it copies that latch into a byte-wide storage array. A protocol front end opens a command with a start address. It then delivers data bytes one strobe at a time and closes the command with a stop strobe. A write-protect level is sampled only at that stop. If protection is off and at least one byte arrived, the block raises `busy` for a fixed number of clock cycles that models the self-timed programming time.

During the first page-length cycles of the busy window, the block rewrites every location of the addressed page in ascending order, one byte per clock. An offset that received a byte gets the staged value. Any other offset gets the value read back from the array at that moment, so a partial write still puts the whole page through the cycle. The address pointer steps only inside the page, so bytes sent past the page end land at its start. The pointer is exposed so the front end can carry on with current-address operations.

Top module: `page_commit_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `arr_we` are 0 and `ptr` is 0.
- R2: Each accepted data byte increments `ptr[5:0]` (the offset within a 64-byte page) modulo 64, and leaves `ptr[13:6]` (the page number) unchanged.
- R3: When more than 64 bytes are sent in one command, each offset keeps the most recent byte written to it, so only the last 64 bytes received reach the array.
- R4: `arr_we` stays 0 until the stop strobe. A data byte or stop strobe that arrives outside an open command is ignored and leaves `ptr` unchanged. If `cmd_start` and `byte_vld` arrive in the same cycle, `cmd_start` wins, and `byte_vld` wins over `stop_pulse`.
- R5: A stop with `wp_pin` = 0 that follows at least one byte sets `busy` from the next cycle. `busy` then stays high for exactly `WC_CYCLES` cycles.
- R6: In busy cycles 0 to 63, `arr_we` is 1 and `arr_waddr` is the page base (`ptr[13:6]`) joined with the cycle index as offset, rising by one each cycle. A loaded offset is written with its staged byte. `arr_we` is 0 for the rest of the busy window.
- R7: An offset that received no byte is written with `arr_rdata`, the current array content at `arr_raddr` (equal to `arr_waddr`).
- R8: A stop with `wp_pin` = 1 starts no write and no busy period, and a new command is accepted on the next cycle. Changes on `wp_pin` after a stop that started a write do not affect that write.
- R9: A command that ends with a stop and has no data bytes starts no write and does not raise `busy`.
- R10: After a write, `ptr` holds the address that follows the last byte written, wrapped within the page. The commit does not change it.
- R11: While `busy` is 1, `cmd_start`, `byte_vld` and `stop_pulse` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle strobe opening a write command |
| cmd_addr | input | ADDR_W | Start address, taken with `cmd_start` |
| byte_vld | input | 1 | One-cycle strobe: a data byte is present |
| byte_data | input | DATA_W | Data byte taken with `byte_vld` |
| stop_pulse | input | 1 | One-cycle strobe closing the command |
| wp_pin | input | 1 | Write-protect level, sampled with `stop_pulse` |
| arr_rdata | input | DATA_W | Combinational read data of the array at `arr_raddr` |
| arr_raddr | output | ADDR_W | Array read address during commit |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr | output | ADDR_W | Internal address pointer |

## Verification
The assertions assume three things. First, the strobes are single-cycle pulses. Second, the array answers a read in the same cycle, so `arr_rdata` matches `arr_raddr` combinationally. Third, `WC_CYCLES` exceeds the page size, so the page walk fits inside the busy window. The stimulus issues at most one strobe per clock, driven between edges. The array model in the bench is a behavioural store read without a register. The bench sets the cycle count to 80, above the 64-byte page.

// File: rtl/page_pkg.sv
// Shared types for the page write buffer and commit controller.
package page_pkg;
    // Controller phase: no command open, collecting bytes, or self-timed write.
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_FILL = 2'd1,
        PS_BUSY = 2'd2
    } pstate_e;
endpackage

// File: rtl/pcc_addr_ptr.sv
// Address pointer. Loaded at command start and bumped per accepted byte.
// A bump changes only the in-page offset bits, so the pointer wraps inside
// its page. Assumes load and bump are never high together.
module pcc_addr_ptr #(
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              bump,
    output logic [ADDR_W-1:0] ptr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] ptr_q;

    // Pointer register: load a new address, or advance the offset modulo page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_addr;
        end else if (bump) begin
            ptr_q <= {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + 1'b1};
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/pcc_page_latch.sv
// One-page staging latch plus a per-offset loaded mask.
// A clear empties the mask. A write stores a byte and marks its offset.
// The read port is combinational. Assumes clear and wr_en are never high together.
module pcc_page_latch #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_off,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_off,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_loaded,
    output logic                          any_loaded
);
    logic [DATA_W-1:0]     bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;

    // Data storage: written per accepted byte; later bytes overwrite earlier.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            bytes_q[wr_off] <= wr_data;
        end
    end

    // Loaded mask: cleared at reset and at each command start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            loaded_q <= '0;
        end else if (wr_en) begin
            loaded_q[wr_off] <= 1'b1;
        end
    end

    assign rd_data    = bytes_q[rd_off];
    assign rd_loaded  = loaded_q[rd_off];
    assign any_loaded = |loaded_q;
endmodule

// File: rtl/pcc_commit_seq.sv
// Command sequencer and self-timed write counter.
// Decides which strobe is taken (start > byte > stop) and samples
// write-protect at the stop. Holds busy for WC_CYCLES cycles, with the
// array write strobe in the first PAGE_BYTES of them.
// Assumes WC_CYCLES > PAGE_BYTES.
module pcc_commit_seq
    import page_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 500000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_start,
    input  logic                          byte_vld,
    input  logic                          stop_pulse,
    input  logic                          wp_pin,
    input  logic                          any_loaded,
    output logic                          take_cmd,
    output logic                          take_byte,
    output logic                          busy,
    output logic                          commit_we,
    output logic [$clog2(PAGE_BYTES)-1:0] commit_off
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WC_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WC_CYCLES - 1);
    localparam logic [CNT_W-1:0] WALK_END = CNT_W'(PAGE_BYTES);

    pstate_e          state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stop_take;
    logic             launch;

    // Strobe arbitration and the launch decision at the stop.
    always_comb begin
        take_cmd  = (state_q != PS_BUSY) && cmd_start;
        take_byte = (state_q == PS_FILL) && !cmd_start && byte_vld;
        stop_take = (state_q == PS_FILL) && !cmd_start && !byte_vld && stop_pulse;
        launch    = stop_take && any_loaded && !wp_pin;
    end

    // Phase register and busy-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else if (state_q == PS_BUSY) begin
            if (cnt_q == CNT_LAST) begin
                state_q <= PS_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (take_cmd) begin
            state_q <= PS_FILL;
        end else if (stop_take) begin
            state_q <= launch ? PS_BUSY : PS_IDLE;
        end
    end

    assign busy       = (state_q == PS_BUSY);
    assign commit_we  = busy && (cnt_q < WALK_END);
    assign commit_off = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/page_commit_ctrl.sv
// Page write buffer and commit controller, top level.
// Stages bytes in a page latch. On a stop with write-protect low,
// rewrites the whole page in ascending order and fills unloaded offsets
// from the array's read data. Assumes a combinational array read and
// single-cycle strobes.
module page_commit_ctrl #(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_pulse,
    input  logic              wp_pin,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_raddr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic              take_cmd;
    logic              take_byte;
    logic              commit_we;
    logic [OFF_W-1:0]  commit_off;
    logic              any_loaded;
    logic [DATA_W-1:0] staged;
    logic              staged_ok;
    logic [ADDR_W-1:0] walk_addr;

    pcc_commit_seq #(
        .PAGE_BYTES(PAGE_BYTES),
        .WC_CYCLES (WC_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .byte_vld  (byte_vld),
        .stop_pulse(stop_pulse),
        .wp_pin    (wp_pin),
        .any_loaded(any_loaded),
        .take_cmd  (take_cmd),
        .take_byte (take_byte),
        .busy      (busy),
        .commit_we (commit_we),
        .commit_off(commit_off)
    );

    pcc_addr_ptr #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cmd),
        .load_addr(cmd_addr),
        .bump     (take_byte),
        .ptr      (ptr)
    );

    pcc_page_latch #(
        .PAGE_BYTES(PAGE_BYTES),
        .DATA_W    (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take_cmd),
        .wr_en     (take_byte),
        .wr_off    (ptr[OFF_W-1:0]),
        .wr_data   (byte_data),
        .rd_off    (commit_off),
        .rd_data   (staged),
        .rd_loaded (staged_ok),
        .any_loaded(any_loaded)
    );

    // Commit address: page base from the pointer (frozen while busy) plus walk offset.
    always_comb begin
        walk_addr = {ptr[ADDR_W-1:OFF_W], commit_off};
    end

    assign arr_raddr = walk_addr;
    assign arr_waddr = walk_addr;
    assign arr_we    = commit_we;
    assign arr_wdata = staged_ok ? staged : arr_rdata;
endmodule

// File: rtl/pcc_checker.sv
// Assertion checker for page_commit_ctrl, attached through bind.
// Assumes single-cycle, mutually exclusive strobes and WC_CYCLES > PAGE_BYTES.
module pcc_checker #(
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              byte_vld,
    input logic              stop_pulse,
    input logic              wp_pin,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_waddr,
    input logic              busy,
    input logic [ADDR_W-1:0] ptr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [31:0] run_len;

    // Length of the current busy run, compared when busy falls.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_walk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_waddr == $past(arr_waddr) + 1'b1));

    p_walk_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_we) |-> (arr_waddr[OFF_W-1:0] == '0));

    p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_pulse) && !$past(wp_pin)));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(WC_CYCLES)));

    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && wp_pin && !busy) |=> !busy);

    p_ptr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

    p_page_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !cmd_start && !busy) |=> (ptr[ADDR_W-1:OFF_W] == $past(ptr[ADDR_W-1:OFF_W])));
endmodule

bind page_commit_ctrl pcc_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .WC_CYCLES (WC_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .byte_vld  (byte_vld),
    .stop_pulse(stop_pulse),
    .wp_pin    (wp_pin),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .busy      (busy),
    .ptr       (ptr)
);

// File: tb/page_commit_ctrl_tb.sv
// Bench: directed and pseudo-random commands against a behavioural model.
// Outputs are compared with the model on every falling edge.
module page_commit_ctrl_tb;
    localparam int AW = 14;
    localparam int DW = 8;
    localparam int PG = 64;
    localparam int WC = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop_pulse = 1'b0;
    logic          wp_pin = 1'b0;
    logic [DW-1:0] arr_rdata;
    logic [AW-1:0] arr_raddr;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    logic          busy;
    logic [AW-1:0] ptr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural array and reference model state.
    logic [DW-1:0] mem [int];
    int            mem_gen = 0;
    logic [DW-1:0] m_buf [int];
    bit            m_open = 0;
    int            m_ptr = 0;
    int            m_cnt = -1;
    int            m_base = 0;
    int            seed = 7;

    always #5 clk = ~clk;

    page_commit_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PG), .WC_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_pulse(stop_pulse),
        .wp_pin(wp_pin), .arr_rdata(arr_rdata), .arr_raddr(arr_raddr),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .busy(busy), .ptr(ptr)
    );

    function automatic logic [DW-1:0] init_val(int a);
        return DW'((a & 8'hFF) ^ ((a >> 8) & 8'hFF) ^ 8'h3C);
    endfunction

    function automatic logic [DW-1:0] mem_rd(int a);
        if (mem.exists(a)) return mem[a];
        return init_val(a);
    endfunction

    function automatic int rnd(int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 32'h7FFFFF) % m;
    endfunction

    task automatic chk(string req, bit ok, int act, int exp, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Combinational array read port.
    always @(arr_raddr or mem_gen) arr_rdata = mem_rd(int'(arr_raddr));

    // Array model: store on write strobe.
    always @(posedge clk) begin
        if (rst_n && arr_we) begin
            mem[int'(arr_waddr)] = arr_wdata;
            mem_gen++;
        end
    end

    // Reference model update.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_ptr = 0; m_cnt = -1; m_buf.delete();
        end else if (m_cnt >= 0) begin
            m_cnt++;
            if (m_cnt == WC) m_cnt = -1;
        end else if (cmd_start) begin
            m_open = 1; m_ptr = int'(cmd_addr); m_buf.delete();
        end else if (byte_vld && m_open) begin
            m_buf[m_ptr % PG] = byte_data;
            m_ptr = (m_ptr / PG) * PG + ((m_ptr + 1) % PG);
        end else if (stop_pulse && m_open) begin
            m_open = 0;
            if (m_buf.num() > 0 && !wp_pin) begin
                m_cnt = 0;
                m_base = (m_ptr / PG) * PG;
            end
        end
    end

    // Per-clock comparison of every output with the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_we;
            e_we = (m_cnt >= 0) && (m_cnt < PG);
            chk("R5", busy == (m_cnt >= 0), int'(busy), int'(m_cnt >= 0), "busy");
            chk("R6", arr_we == e_we, int'(arr_we), int'(e_we), "arr_we");
            chk("R2", int'(ptr) == m_ptr, int'(ptr), m_ptr, "ptr");
            if (e_we) begin
                int ea;
                logic [DW-1:0] ed;
                ea = m_base + m_cnt;
                ed = m_buf.exists(m_cnt) ? m_buf[m_cnt] : mem_rd(ea);
                chk("R6", int'(arr_waddr) == ea, int'(arr_waddr), ea, "arr_waddr");
                chk("R7", arr_wdata == ed, int'(arr_wdata), int'(ed), "arr_wdata");
            end
        end
    end

    task automatic t_cmd(int a);
        cmd_start = 1'b1; cmd_addr = AW'(a);
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic t_byte(int d);
        byte_vld = 1'b1; byte_data = DW'(d);
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic t_stop(bit w);
        stop_pulse = 1'b1; wp_pin = w;
        @(negedge clk);
        stop_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1", busy == 1'b0, int'(busy), 0, "busy in reset");
        chk("R1", arr_we == 1'b0, int'(arr_we), 0, "arr_we in reset");
        chk("R1", ptr == '0, int'(ptr), 0, "ptr in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R4: stray byte and stop with no open command are ignored.
        t_byte(8'h11); t_stop(1'b0);
        chk("R4", ptr == '0, int'(ptr), 0, "ptr after stray byte");
        chk("R4", busy == 1'b0, int'(busy), 0, "busy after stray stop");

        // Single byte write; R10 pointer, R7 neighbour refreshed unchanged.
        t_cmd(16'h0105); t_byte(8'hAA);
        chk("R4", arr_we == 1'b0, int'(arr_we), 0, "arr_we before stop");
        t_stop(1'b0);
        chk("R5", busy == 1'b1, int'(busy), 1, "busy after stop");
        wait_idle();
        chk("R10", int'(ptr) == 16'h0106, int'(ptr), 16'h0106, "ptr after byte write");
        chk("R6", mem_rd(16'h0105) == 8'hAA, int'(mem_rd(16'h0105)), 8'hAA, "written byte");
        chk("R7", mem_rd(16'h0104) == init_val(16'h0104), int'(mem_rd(16'h0104)),
            int'(init_val(16'h0104)), "refreshed byte");

        // R2: in-page wrap from offset 0x3E.
        t_cmd(16'h2F3E);
        for (int i = 0; i < 5; i++) t_byte(8'h50 + i);
        chk("R2", int'(ptr) == 16'h2F03, int'(ptr), 16'h2F03, "ptr after wrap");
        t_stop(1'b0);
        wait_idle();
        chk("R2", mem_rd(16'h2F00) == 8'h52, int'(mem_rd(16'h2F00)), 8'h52, "wrapped byte");
        chk("R2", mem_rd(16'h3000) == init_val(16'h3000), int'(mem_rd(16'h3000)),
            int'(init_val(16'h3000)), "next page untouched");

        // R3: 70 bytes, the first six offsets are overwritten.
        t_cmd(16'h0400);
        for (int i = 0; i < 70; i++) t_byte(i);
        t_stop(1'b0);
        wait_idle();
        chk("R3", mem_rd(16'h0403) == 8'd67, int'(mem_rd(16'h0403)), 67, "overwritten offset");
        chk("R3", mem_rd(16'h0410) == 8'd16, int'(mem_rd(16'h0410)), 16, "kept offset");

        // R8: protected stop, then an immediate new command; wp toggling while busy.
        t_cmd(16'h0800); t_byte(8'h99); t_stop(1'b1);
        chk("R8", busy == 1'b0, int'(busy), 0, "busy after protected stop");
        t_cmd(16'h0900); t_byte(8'h77); t_stop(1'b0);
        chk("R8", busy == 1'b1, int'(busy), 1, "command after protected stop");
        wp_pin = 1'b1;
        repeat (10) @(negedge clk);
        wp_pin = 1'b0;
        wait_idle();
        chk("R8", mem_rd(16'h0900) == 8'h77, int'(mem_rd(16'h0900)), 8'h77, "write despite wp toggle");
        chk("R8", mem_rd(16'h0800) == init_val(16'h0800), int'(mem_rd(16'h0800)),
            int'(init_val(16'h0800)), "protected byte untouched");

        // R9: address-only command.
        t_cmd(16'h0123); t_stop(1'b0);
        chk("R9", busy == 1'b0, int'(busy), 0, "busy after empty command");
        chk("R9", int'(ptr) == 16'h0123, int'(ptr), 16'h0123, "ptr after empty command");

        // R11: strobes during busy are ignored.
        t_cmd(16'h0A10); t_byte(8'h01); t_stop(1'b0);
        t_cmd(16'h1234); t_byte(8'hEE); t_stop(1'b0);
        chk("R11", int'(ptr) == 16'h0A11, int'(ptr), 16'h0A11, "ptr during busy");
        wait_idle();
        chk("R11", busy == 1'b0, int'(busy), 0, "no second cycle");
        chk("R11", mem_rd(16'h1234) == init_val(16'h1234), int'(mem_rd(16'h1234)),
            int'(init_val(16'h1234)), "ignored byte not written");

        // R4: same-cycle priority, cmd_start over byte_vld.
        cmd_start = 1'b1; cmd_addr = AW'(16'h0C05); byte_vld = 1'b1; byte_data = 8'h42;
        @(negedge clk);
        cmd_start = 1'b0; byte_vld = 1'b0;
        chk("R4", int'(ptr) == 16'h0C05, int'(ptr), 16'h0C05, "start wins over byte");
        t_stop(1'b0);
        chk("R9", busy == 1'b0, int'(busy), 0, "no bytes after priority case");

        // Pseudo-random commands, checked by the per-clock model.
        for (int k = 0; k < 20; k++) begin
            int n;
            t_cmd(rnd(1 << AW));
            n = rnd(12);
            for (int j = 0; j < n; j++) t_byte(rnd(256));
            t_stop(rnd(4) == 0);
            wait_idle();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule